// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a steady periodic event from the system clock. A fixed divide-by-16 prescaler drives a 20-bit interval counter. The counter runs from zero up to a limit set by software and then returns to zero. Each return to zero is one completed period. At that point the block raises a sticky status flag and steps a 12-bit overflow count. If the interrupt is enabled, it also drives a level interrupt.

Software reaches the block through four 32-bit words on a simple synchronous bus that has one read strobe and one write strobe. Two of these words return the same packed value: the live interval count together with the overflow count. Reading one of them acknowledges the event, which clears the flag and drops the interrupt. Reading the other has no side effect, so software can sample the timer without losing an event.

Top module: `interval_timer`

## Requirements
- R1: The 4-bit offset selects mode (0x0), status (0x4), value (0x8) or image (0xC); other offsets read as zero. Read data is registered, appears the cycle after the read strobe, and holds until the next read.
- R2: After reset, mode reads 0x000FFFFF, status reads 0, value reads 0, irq is low and the counter is stopped.
- R3: The mode word stores all 32 written bits and reads them back. Bits [19:0] are the interval limit, bit 24 is run enable and bit 25 is interrupt enable. A mode write with bit 24 clear freezes the count.
- R4: A mode write with bit 24 set clears the prescaler and the interval counter. The counter then advances once every 16 clocks, and after the value equal to the limit it returns to 0, so one period is limit+1 steps.
- R5: Each period end sets status bit 0, and the flag stays set until it is acknowledged.
- R6: The value and image words return the interval count in bits [19:0] and the overflow count in bits [31:20]. The overflow count steps by one at each period end and wraps from 0xFFF to 0.
- R7: irq is a level output. It rises at a period end only when mode bit 25 is set, and then stays high until acknowledged.
- R8: A read of the value word clears status and irq. It returns the count word as it stood in the cycle of the strobe.
- R9: A read of the image word returns the same word and changes neither status, irq nor any count.
- R10: Writes to offsets 0x4, 0x8 and 0xC change nothing.
- R11: If a period end and a value read occur in the same cycle, the event wins: status and irq stay set, and the read returns the word from before the period end. A mode write in the cycle of a would-be period end suppresses that period end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word offset within the block |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle: a period end with an acknowledging value read, and a period end with a mode rewrite. Directed tests count clocks from the enabling write so that the strobe is captured on exactly the edge where the prescaler expires on the limit. After the read that coincides with a period end, status and irq must still be set and the returned word must be the one from before the period end. The mode rewrite that coincides with a period end must leave status clear. Random traffic with short intervals also produces both collisions many times, and a bench model of the register behaviour checks every read word and the irq level.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 20;
  localparam int unsigned OVF_W  = 12;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned EN_BIT = 24;
  localparam int unsigned IE_BIT = 25;
  localparam logic [DATA_W-1:0] MODE_RST = 32'h000F_FFFF;

  typedef enum logic [OFF_W-1:0] {
    OFF_MODE = 4'h0,
    OFF_STAT = 4'h4,
    OFF_VAL  = 4'h8,
    OFF_IMG  = 4'hC
  } off_e;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    tick_o = run_i && (pre_q == {PRE_W{1'b1}});
    pre_d  = pre_q;
    if (clear_i)
      pre_d = '0;
    else if (run_i)
      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_W-1:0] ovf_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;

  always_comb begin
    wrap_o = tick_i && (cnt_q == limit_i);
    cnt_d  = cnt_q;
    if (clear_i || wrap_o)
      cnt_d = '0;
    else if (tick_i)
      cnt_d = cnt_q + 1'b1;
    ovf_d = wrap_o ? ovf_q + 1'b1 : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OVF_W-1:0]  ovf_i,
  output logic [DATA_W-1:0] mode_o,
  output logic              mode_wr_o,
  output logic              status_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mode_q, mode_d;
  logic              stat_q, stat_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] rd_word;
  logic              val_rd;

  always_comb begin
    mode_wr_o = wr_en_i && (addr_i == OFF_MODE);
    val_rd    = rd_en_i && (addr_i == OFF_VAL);

    case (addr_i)
      OFF_MODE:        rd_word = mode_q;
      OFF_STAT:        rd_word = {{(DATA_W-1){1'b0}}, stat_q};
      OFF_VAL, OFF_IMG: rd_word = {ovf_i, cnt_i};
      default:         rd_word = '0;
    endcase

    mode_d  = mode_wr_o ? wdata_i : mode_q;
    rdata_d = rd_en_i ? rd_word : rdata_q;

    stat_d = stat_q;
    if (wrap_i)      stat_d = 1'b1;
    else if (val_rd) stat_d = 1'b0;

    irq_d = irq_q;
    if (wrap_i && mode_q[IE_BIT]) irq_d = 1'b1;
    else if (val_rd)              irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      stat_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      stat_q  <= stat_d;
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
    end
  end

  assign mode_o   = mode_q;
  assign status_o = stat_q;
  assign irq_o    = irq_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q;
  logic              mode_wr;
  logic              run;
  logic              load;
  logic              tick;
  logic              wrap;
  logic              status;
  logic [CNT_W-1:0]  cnt;
  logic [OVF_W-1:0]  ovf;

  assign run  = mode_q[EN_BIT] && !mode_wr;
  assign load = mode_wr && wdata[EN_BIT];

  ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .clear_i (load),
    .tick_o  (tick)
  );

  ivt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .tick_i  (tick),
    .limit_i (mode_q[CNT_W-1:0]),
    .cnt_o   (cnt),
    .ovf_o   (ovf),
    .wrap_o  (wrap)
  );

  ivt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .wdata_i   (wdata),
    .wrap_i    (wrap),
    .cnt_i     (cnt),
    .ovf_i     (ovf),
    .mode_o    (mode_q),
    .mode_wr_o (mode_wr),
    .status_o  (status),
    .irq_o     (irq),
    .rdata_o   (rdata)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import ivt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [CNT_W-1:0] iv,
  input logic             en,
  input logic             mode_wr,
  input logic             status,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [OVF_W-1:0] ovf,
  input logic             wrap
);
  a_r5_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> status);

  a_r7_irq_implies_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

  a_r8_value_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h8 && !wrap) |=> (!status && !irq));

  a_r9_image_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hC && !wrap) |=> ($stable(status) && $stable(irq) && $stable(ovf)));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= iv));

  a_r6_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf == OVF_W'($past(ovf) + 1'b1)));

  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !mode_wr) |=> $stable(cnt));

  a_r11_write_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> !wrap);

  a_r10_side_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 4'h0 && !wrap && !rd_en) |=> ($stable(status) && $stable(ovf)));
endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .iv      (mode_q[ivt_pkg::CNT_W-1:0]),
  .en      (mode_q[ivt_pkg::EN_BIT]),
  .mode_wr (mode_wr),
  .status  (status),
  .irq     (irq),
  .cnt     (cnt),
  .ovf     (ovf),
  .wrap    (wrap)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errs   = 0;

  interval_timer uut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model built from the requirements
  logic [31:0] m_mode;
  logic [3:0]  m_pre;
  logic [19:0] m_cnt;
  logic [11:0] m_ovf;
  logic        m_st;
  logic        m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_word(input logic [3:0] a);
    case (a)
      4'h0:       return m_mode;
      4'h4:       return {31'b0, m_st};
      4'h8, 4'hC: return {m_ovf, m_cnt};
      default:    return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic wr0, vrd, tk, wp, ie_old;
    if (!rst_n) begin
      m_mode = 32'h000F_FFFF; m_pre = 0; m_cnt = 0; m_ovf = 0;
      m_st = 0; m_irq = 0; m_rd = 0;
    end else begin
      wr0    = wr_en && addr == 4'h0;
      vrd    = rd_en && addr == 4'h8;
      ie_old = m_mode[25];
      if (rd_en) m_rd = model_word(addr);
      tk = m_mode[24] && !wr0 && m_pre == 4'hF;
      wp = tk && m_cnt == m_mode[19:0];
      if (wr0) begin
        m_mode = wdata;
        if (wdata[24]) begin m_pre = 0; m_cnt = 0; end
      end else if (m_mode[24]) begin
        m_pre = m_pre + 1'b1;
        if (tk) m_cnt = wp ? 20'd0 : m_cnt + 1'b1;
      end
      if (wp) m_ovf = m_ovf + 1'b1;
      if (wp) m_st = 1'b1; else if (vrd) m_st = 1'b0;
      if (wp && ie_old) m_irq = 1'b1; else if (vrd) m_irq = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic read_model(input logic [3:0] a, input string tag);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, m_rd);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned sd;
    addr = 0; wr_en = 0; rd_en = 0; wdata = 0; rst_n = 0;
    sd = $urandom(32'd90210);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    bus_read(4'h0, d); check("R2 mode reset", d, 32'h000F_FFFF);
    bus_read(4'h4, d); check("R2 status reset", d, 32'h0);
    bus_read(4'h8, d); check("R2 value reset", d, 32'h0);
    check("R2 irq reset", {31'b0, irq}, 32'h0);
    // R1 unmapped offset and hold
    bus_read(4'h2, d); check("R1 unmapped offset", d, 32'h0);
    repeat (3) @(negedge clk);
    check("R1 rdata held", rdata, 32'h0);

    // R10 writes to other offsets ignored
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'h0, d); check("R10 mode untouched", d, 32'h000F_FFFF);
    bus_read(4'h4, d); check("R10 status untouched", d, 32'h0);
    bus_read(4'hC, d); check("R10 count untouched", d, 32'h0);

    // R3 full mode readback
    bus_write(4'h0, 32'hA0F0_0005);
    bus_read(4'h0, d); check("R3 mode readback", d, 32'hA0F0_0005);

    // R4 start: count cleared, R5 flag, R7 no irq when disabled
    bus_write(4'h0, 32'h0100_0002);
    bus_read(4'hC, d); check("R4 count starts at zero", d, 32'h0);
    repeat (100) @(negedge clk);
    bus_read(4'h4, d); check("R5 status set", d, 32'h1);
    check("R7 irq stays low when disabled", {31'b0, irq}, 32'h0);
    read_model(4'hC, "R9 image word");
    bus_read(4'h4, d); check("R9 image leaves status", d, 32'h1);
    read_model(4'h8, "R8 value word");
    bus_read(4'h4, d); check("R8 status cleared", d, 32'h0);

    // R3 stop freezes count
    bus_write(4'h0, 32'h0000_0002);
    read_model(4'hC, "R3 frozen count a");
    repeat (70) @(negedge clk);
    read_model(4'hC, "R3 frozen count b");

    // R7 irq raised, R8 cleared
    bus_write(4'h0, 32'h0300_0000);
    repeat (40) @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 32'h1);
    read_model(4'h8, "R8 acknowledge read");
    check("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R11 value read on the wrap edge
    do_reset();
    bus_write(4'h0, 32'h0300_0001);
    repeat (30) @(negedge clk);
    bus_read(4'h8, d); check("R11 read returns pre-wrap word", d, 32'h0000_0001);
    bus_read(4'h4, d); check("R11 status survives", d, 32'h1);
    check("R11 irq survives", {31'b0, irq}, 32'h1);

    // R11 mode write on the wrap edge suppresses it
    do_reset();
    bus_write(4'h0, 32'h0300_0000);
    repeat (14) @(negedge clk);
    bus_write(4'h0, 32'h0300_0000);
    bus_read(4'h4, d); check("R11 write blocks wrap", d, 32'h0);
    check("R11 no irq after blocked wrap", {31'b0, irq}, 32'h0);

    // R6 overflow count wraps
    do_reset();
    bus_write(4'h0, 32'h0100_0000);
    repeat (65526) @(negedge clk);
    bus_read(4'hC, d); check("R6 overflow at 0xFFF", d, 32'hFFF0_0000);
    repeat (14) @(negedge clk);
    bus_read(4'hC, d); check("R6 overflow wrapped to 0", d, 32'h0);

    // Random traffic against the model
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom % 8;
      repeat ($urandom % 40) @(negedge clk);
      case (op)
        0: read_model(4'h8, "R8 random value read");
        1: read_model(4'hC, "R9 random image read");
        2: read_model(4'h4, "R5 random status read");
        3: read_model(4'h0, "R3 random mode read");
        4: bus_write(4'h0, {6'b0, 2'($urandom), 4'b0, 18'b0, 2'($urandom)});
        5: bus_write(4'h4 << ($urandom % 2), $urandom);
        6: read_model(4'($urandom), "R1 random offset read");
        default: read_model(4'hC, "R6 random count read");
      endcase
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule